// File: doc/BRIEF.md
# Multicast Crossbar Master Port

This block sits between one master and a small crossbar. When it is idle it captures a single message from the master: a data word, an address, a write flag and a bit mask that names every slave the message is meant for. It then asks the crossbar arbiter for access to each of those slaves. Grants that arrive over several cycles are collected. Any slave that has not yet been granted is asked for again on every following cycle. Once every target slave has been granted, the port frees itself for the next message.

In the other direction, the port passes slave responses back to the master. A response carries the read data and the address of the request it answers. When more than one slave responds in the same cycle, the lowest-numbered one is forwarded. The arbiter, the fabric and the slave logic are outside this block.

Top module: `xbar_mcast_port`

## Requirements
- R1: While reset (`rst_n` low) is held and after it is released, `busy`, `arb_req` and `rsp_valid` are 0 until a message is accepted or a response arrives.
- R2: A message is accepted at a clock edge where `msg_valid` is 1, `busy` is 0 and `msg_targets` is nonzero. From the next cycle, `busy` is 1 and `out_data`, `out_addr` and `out_write` show the captured fields.
- R3: While `busy` is 1, `msg_valid` and the message inputs are ignored, and `out_data`, `out_addr` and `out_write` hold the captured message.
- R4: `arb_req` equals the target mask with the already-granted slaves removed while `busy` is 1, and is 0 while `busy` is 0. Bit i of the mask and of `arb_req` stands for slave i.
- R5: A target slave that has not been granted is requested again on every cycle until it is granted. A grant bit on a slave that is not being requested in that cycle has no effect.
- R6: In the cycle after the one in which the collected grants come to equal the target mask, `busy` is 0, and a new message can be accepted in that same cycle.
- R7: A message with an all-zero target mask is dropped: `busy` stays 0 and `arb_req` stays 0.
- R8: `rsp_valid` is 1 in the cycle after any bit of `slv_rsp_valid` is 1, and 0 otherwise. `rsp_data` and `rsp_addr` then carry the data and address of the lowest-numbered responding slave. Slave i's fields sit at bits [i*DW +: DW] and [i*AW +: AW].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| msg_valid | input | 1 | Master offers a message |
| msg_data | input | DW | Message data |
| msg_addr | input | AW | Message address |
| msg_write | input | 1 | 1 = write, 0 = read |
| msg_targets | input | NS | Bit mask of target slaves |
| busy | output | 1 | Port is holding a message |
| out_data | output | DW | Held message data, driven toward the fabric |
| out_addr | output | AW | Held message address |
| out_write | output | 1 | Held write flag |
| arb_req | output | NS | Per-slave request to the arbiter |
| arb_gnt | input | NS | Per-slave grant from the arbiter |
| slv_rsp_valid | input | NS | Per-slave response strobe |
| slv_rsp_data | input | NS*DW | Packed response data |
| slv_rsp_addr | input | NS*AW | Packed original request addresses |
| rsp_valid | output | 1 | Response strobe to the master |
| rsp_data | output | DW | Forwarded response data |
| rsp_addr | output | AW | Forwarded original address |

## Verification
The bench targets four kinds of corner case:
- Grants that arrive one slave at a time over many cycles, mixed with stray grant bits on slaves that are not being requested. A design that took those stray bits would finish early, and a design that dropped an ungranted request would hang.
- All grants arriving in the very first request cycle. This checks that `busy` falls exactly one cycle later and that a message offered in that idle cycle is taken.
- An all-zero target mask, and new messages offered while the port is busy. A wrong design would then stall forever or overwrite the held message.
- Several slaves responding in the same cycle, where forwarding any slave other than the lowest-numbered one is reported.

// File: rtl/xbar_mcast_port.sv
module xbar_mcast_port #(
  parameter int DW = 8,
  parameter int AW = 16,
  parameter int NS = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             msg_valid,
  input  logic [DW-1:0]    msg_data,
  input  logic [AW-1:0]    msg_addr,
  input  logic             msg_write,
  input  logic [NS-1:0]    msg_targets,
  output logic             busy,
  output logic [DW-1:0]    out_data,
  output logic [AW-1:0]    out_addr,
  output logic             out_write,
  output logic [NS-1:0]    arb_req,
  input  logic [NS-1:0]    arb_gnt,
  input  logic [NS-1:0]    slv_rsp_valid,
  input  logic [NS*DW-1:0] slv_rsp_data,
  input  logic [NS*AW-1:0] slv_rsp_addr,
  output logic             rsp_valid,
  output logic [DW-1:0]    rsp_data,
  output logic [AW-1:0]    rsp_addr
);

  logic [NS-1:0] tgt_q, got_q, got_nx;
  logic          take, done;
  logic [DW-1:0] pick_data;
  logic [AW-1:0] pick_addr;

  assign take    = msg_valid && !busy && (msg_targets != '0);
  assign arb_req = busy ? (tgt_q & ~got_q) : '0;
  assign got_nx  = got_q | (arb_gnt & arb_req);
  assign done    = busy && (got_nx == tgt_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      tgt_q     <= '0;
      got_q     <= '0;
      out_data  <= '0;
      out_addr  <= '0;
      out_write <= 1'b0;
    end else if (take) begin
      busy      <= 1'b1;
      tgt_q     <= msg_targets;
      got_q     <= '0;
      out_data  <= msg_data;
      out_addr  <= msg_addr;
      out_write <= msg_write;
    end else if (busy) begin
      got_q <= got_nx;
      if (done) busy <= 1'b0;
    end
  end

  always_comb begin
    pick_data = '0;
    pick_addr = '0;
    for (int i = NS - 1; i >= 0; i--) begin
      if (slv_rsp_valid[i]) begin
        pick_data = slv_rsp_data[i*DW +: DW];
        pick_addr = slv_rsp_addr[i*AW +: AW];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
      rsp_addr  <= '0;
    end else begin
      rsp_valid <= |slv_rsp_valid;
      if (|slv_rsp_valid) begin
        rsp_data <= pick_data;
        rsp_addr <= pick_addr;
      end
    end
  end

  assert_idle_no_req_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> arb_req == '0);
  assert_busy_has_req_R5: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> arb_req != '0);
  assert_granted_dropped_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && (arb_req & arb_gnt) != '0) |=> (arb_req & $past(arb_req & arb_gnt)) == '0);
  assert_rise_needs_msg_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(msg_valid && msg_targets != '0));
  assert_msg_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(out_addr) && $stable(out_data) && $stable(out_write)));
  assert_rsp_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(slv_rsp_valid != '0));

endmodule

// File: tb/xbar_mcast_port_bench.sv
module xbar_mcast_port_bench;
  localparam int DW = 8, AW = 16, NS = 4;

  logic clk = 0, rst_n = 0;
  logic msg_valid = 0, msg_write = 0;
  logic [DW-1:0] msg_data = 0;
  logic [AW-1:0] msg_addr = 0;
  logic [NS-1:0] msg_targets = 0, arb_gnt = 0, slv_rsp_valid = 0;
  logic [NS*DW-1:0] slv_rsp_data = 0;
  logic [NS*AW-1:0] slv_rsp_addr = 0;
  logic busy, out_write, rsp_valid;
  logic [DW-1:0] out_data, rsp_data;
  logic [AW-1:0] out_addr, rsp_addr;
  logic [NS-1:0] arb_req;

  xbar_mcast_port #(.DW(DW), .AW(AW), .NS(NS)) u_xbar_mcast_port (
    .clk(clk), .rst_n(rst_n), .msg_valid(msg_valid), .msg_data(msg_data),
    .msg_addr(msg_addr), .msg_write(msg_write), .msg_targets(msg_targets),
    .busy(busy), .out_data(out_data), .out_addr(out_addr), .out_write(out_write),
    .arb_req(arb_req), .arb_gnt(arb_gnt), .slv_rsp_valid(slv_rsp_valid),
    .slv_rsp_data(slv_rsp_data), .slv_rsp_addr(slv_rsp_addr),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_addr(rsp_addr));

  always #10 clk = ~clk;

  int checks = 0, failures = 0;
  bit finished = 0;

  logic e_busy = 0, e_wr = 0, e_rsp = 0;
  logic [NS-1:0] e_tgt = 0, e_got = 0;
  logic [DW-1:0] e_data = 0, e_rdata = 0;
  logic [AW-1:0] e_addr = 0, e_raddr = 0;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [NS-1:0] exp_req();
    return e_busy ? (e_tgt & ~e_got) : '0;
  endfunction

  task automatic step();
    chk("R6 busy", 32'(busy), 32'(e_busy));
    chk("R4 arb_req", 32'(arb_req), 32'(exp_req()));
    if (e_busy) begin
      chk("R3 out_addr", 32'(out_addr), 32'(e_addr));
      chk("R3 out_data", 32'(out_data), 32'(e_data));
      chk("R3 out_write", 32'(out_write), 32'(e_wr));
    end
    chk("R8 rsp_valid", 32'(rsp_valid), 32'(e_rsp));
    if (e_rsp) begin
      chk("R8 rsp_data", 32'(rsp_data), 32'(e_rdata));
      chk("R8 rsp_addr", 32'(rsp_addr), 32'(e_raddr));
    end
    @(posedge clk);
    #1;
    if (!e_busy) begin
      if (msg_valid && msg_targets != 0) begin
        e_busy = 1; e_tgt = msg_targets; e_got = 0;
        e_data = msg_data; e_addr = msg_addr; e_wr = msg_write;
      end
    end else begin
      e_got = e_got | (arb_gnt & e_tgt);
      if (e_got == e_tgt) e_busy = 0;
    end
    e_rsp = |slv_rsp_valid;
    if (e_rsp) begin
      for (int i = NS - 1; i >= 0; i--)
        if (slv_rsp_valid[i]) begin
          e_rdata = slv_rsp_data[i*DW +: DW];
          e_raddr = slv_rsp_addr[i*AW +: AW];
        end
    end
    @(negedge clk);
  endtask

  task automatic idle_in();
    msg_valid = 0; arb_gnt = 0; slv_rsp_valid = 0;
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    #(20 * 20000);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk("R1 busy in reset", 32'(busy), 0);
    chk("R1 req in reset", 32'(arb_req), 0);
    chk("R1 rsp in reset", 32'(rsp_valid), 0);
    rst_n = 1;
    @(negedge clk);
    step();

    // R7: zero mask dropped
    msg_valid = 1; msg_targets = 0; msg_addr = 16'h1111; msg_data = 8'h11;
    step();
    idle_in();
    chk("R7 busy after zero mask", 32'(busy), 0);
    chk("R7 req after zero mask", 32'(arb_req), 0);
    step();

    // R2/R6: all grants at once, back-to-back acceptance
    msg_valid = 1; msg_targets = 4'b1010; msg_addr = 16'hBEEF; msg_data = 8'h5A; msg_write = 1;
    step();
    chk("R2 busy after accept", 32'(busy), 1);
    chk("R2 out_addr", 32'(out_addr), 32'h0000BEEF);
    msg_targets = 4'b0001; msg_addr = 16'h2222; msg_data = 8'h22; msg_write = 0;
    arb_gnt = 4'b1010;
    step();
    chk("R6 busy low after full grant", 32'(busy), 0);
    step();
    chk("R6 next message taken", 32'(out_addr), 32'h00002222);
    msg_valid = 0; arb_gnt = 0;
    step(); step();
    arb_gnt = 4'b0001;
    step();
    idle_in();
    step();

    // R5: stray grants ignored, slow grants, valid while busy (R3)
    msg_valid = 1; msg_targets = 4'b0110; msg_addr = 16'h3333; msg_data = 8'h33;
    step();
    msg_addr = 16'h4444; msg_data = 8'h44; msg_targets = 4'b1111;
    arb_gnt = 4'b1001;
    step();
    chk("R5 stray grant ignored", 32'(arb_req), 32'b0110);
    arb_gnt = 4'b0100;
    step();
    chk("R5 re-request ungranted", 32'(arb_req), 32'b0010);
    arb_gnt = 0;
    step(); step();
    chk("R3 held under new valid", 32'(out_addr), 32'h00003333);
    arb_gnt = 4'b0010;
    step();
    idle_in();
    step();

    // R8: simultaneous responses
    slv_rsp_valid = 4'b1100;
    for (int i = 0; i < NS; i++) begin
      slv_rsp_data[i*DW +: DW] = 8'(8'hA0 + i);
      slv_rsp_addr[i*AW +: AW] = 16'(16'hC000 + i);
    end
    step();
    chk("R8 lowest responder data", 32'(rsp_data), 32'hA2);
    slv_rsp_valid = 0;
    step();

    // random traffic
    for (int n = 0; n < 3000; n++) begin
      msg_valid = ($urandom % 3) != 0;
      msg_targets = NS'($urandom);
      msg_data = DW'($urandom);
      msg_addr = AW'($urandom);
      msg_write = 1'($urandom);
      arb_gnt = NS'($urandom) & NS'($urandom);
      slv_rsp_valid = (($urandom % 4) == 0) ? NS'($urandom) : '0;
      slv_rsp_data = NS*DW'($urandom);
      slv_rsp_addr = {$urandom, $urandom};
      step();
    end
    idle_in();
    step();

    finished = 1;
    summary();
    $finish;
  end
endmodule